// File: doc/BRIEF.md
# Split-Stream Bidirectional Fetch Address Sequencer

This block supplies the two fetch addresses that one thread needs when each instruction bundle is stored as two halves in two separate code streams. The streams sit head-to-head in memory around a shared entry address. One stream is read upward from that address and the other is read downward, so a single branch target serves both. Every cycle that both sides have work, one half-bundle from each stream issues, and the two halves execute together.

A control transfer loads the shared entry address into both counters and clears any idle time still pending on either side. Branches only ever land on the entry of a single-entry, multiple-exit block, so the block never needs a mid-block resume point. After a branch, the upward counter moves forward by the byte length of the half-bundle it just issued. The downward counter moves back by the byte length of its own issued half-bundle.

Some cycles have work for only one side, or for neither. The half-bundle that issues on one side carries, in its spare alignment bits, a count of cycles for which the opposite side stays idle. The idle side then holds its address and lowers its issue flag. When more idle cycles are needed than the spare bits can hold, the compiler places explicit no-op half-bundles instead. The sequencer takes no part in that choice. A global stall freezes everything except a branch.

Top module: `dsps_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, both addresses become RESET_ADDR (default 0) and both skip counters become zero, so that after reset, with `stall` low, both issue flags are 1.
- R2: When `branch_valid` is 1 at an edge, both `fwd_addr` and `bwd_addr` take `branch_target` and both skip counters clear, so both sides issue in the next unstalled cycle.
- R3: In a cycle with `fwd_issue` = 1 and no branch, `fwd_addr` increases by `fwd_len` at the edge.
- R4: In a cycle with `bwd_issue` = 1 and no branch, `bwd_addr` decreases by `bwd_len` at the edge, wrapping modulo 2^ADDR_W.
- R5: While `stall` is 1 (and no branch), both issue flags are 0 and both addresses and both skip counters keep their values.
- R6: A value N on `fwd_hole_skip` while both sides issue makes the backward side idle for the next N unstalled cycles: `bwd_issue` is 0 and `bwd_addr` holds. After those cycles it issues again.
- R7: A value N on `bwd_hole_skip` while both sides issue makes the forward side idle for the next N unstalled cycles, in the same way.
- R8: A hole count presented by a side that issues while the opposite side is idle has no effect. The idle side resumes after its original count.
- R9: A hole count of zero causes no idle cycle. Nonzero counts on both sides in the same cycle make both sides idle together, with both addresses held.
- R10: A branch takes effect even while `stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Global freeze of addresses and skip counters |
| branch_valid | input | 1 | Control transfer this cycle |
| branch_target | input | ADDR_W | Entry address loaded into both counters |
| fwd_len | input | LEN_W | Byte length of the forward half-bundle now issuing |
| bwd_len | input | LEN_W | Byte length of the backward half-bundle now issuing |
| fwd_hole_skip | input | SKIP_W | Idle count for the backward side, from the forward half-bundle's hole |
| bwd_hole_skip | input | SKIP_W | Idle count for the forward side, from the backward half-bundle's hole |
| fwd_addr | output | ADDR_W | Fetch address of the upward-moving stream |
| bwd_addr | output | ADDR_W | Fetch address of the downward-moving stream |
| fwd_issue | output | 1 | Forward half-bundle issues this cycle |
| bwd_issue | output | 1 | Backward half-bundle issues this cycle |

## Verification
The hardest situations to reach are the ones where skip counts interact with each other. These are a hole count offered while the receiving side is already idle, counts on both sides at once, and a stall or branch landing while a counter is still running. The stimulus table reaches each of these by first issuing a half-bundle with a nonzero hole count. In the next rows it presents a competing count, a stall or a branch, and in each row it checks the issue flags and the held or moved addresses. A directed sequence after a mid-run reset stalls for three cycles with a backward idle pending. It then confirms that the idle length is unchanged and that the backward address wraps below zero.

// File: rtl/dsps_pkg.sv
package dsps_pkg;

    typedef enum logic {
        SIDE_UP   = 1'b0,
        SIDE_DOWN = 1'b1
    } side_dir_e;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_LEN_W  = 6;
    localparam int unsigned DEF_SKIP_W = 3;
    localparam int unsigned NUM_SIDES  = 2;

endpackage

// File: rtl/dsps_skip_ctr.sv
module dsps_skip_ctr #(
    parameter int unsigned SKIP_W = dsps_pkg::DEF_SKIP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              branch_valid,
    input  logic              peer_issue,
    input  logic [SKIP_W-1:0] peer_hole,
    output logic              idle
);
    logic [SKIP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || branch_valid) begin
            cnt_q <= '0;
        end else if (!stall) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (peer_issue) begin
                cnt_q <= peer_hole;
            end
        end
    end

    assign idle = (cnt_q != '0);

    assert_branch_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(branch_valid)) |-> (cnt_q == '0));

    assert_stall_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stall && !branch_valid)) |-> $stable(cnt_q));

    assert_skip_countdown_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!stall && !branch_valid && cnt_q != '0))
        |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dsps_addr_reg.sv
module dsps_addr_reg
    import dsps_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter side_dir_e   DIR        = SIDE_UP,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              branch_valid,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic [LEN_W-1:0]  step_len,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] step_ext;
    logic [ADDR_W-1:0] next_step;

    assign step_ext = {{PAD_W{1'b0}}, step_len};

    generate
        if (DIR == SIDE_UP) begin : g_up
            assign next_step = addr + step_ext;
            assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(advance && !branch_valid))
                |-> (addr == $past(addr) + {{PAD_W{1'b0}}, $past(step_len)}));
        end else begin : g_down
            assign next_step = addr - step_ext;
            assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(advance && !branch_valid))
                |-> (addr == $past(addr) - {{PAD_W{1'b0}}, $past(step_len)}));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= RESET_ADDR;
        end else if (branch_valid) begin
            addr <= branch_target;
        end else if (advance) begin
            addr <= next_step;
        end
    end

    assert_branch_load_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(branch_valid)) |-> (addr == $past(branch_target)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!advance && !branch_valid)) |-> $stable(addr));

endmodule

// File: rtl/dsps_side.sv
module dsps_side
    import dsps_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned SKIP_W     = DEF_SKIP_W,
    parameter side_dir_e   DIR        = SIDE_UP,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              branch_valid,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              peer_issue,
    input  logic [SKIP_W-1:0] peer_hole,
    output logic [ADDR_W-1:0] addr,
    output logic              issue
);
    logic idle;

    dsps_skip_ctr #(.SKIP_W(SKIP_W)) skip_i (
        .clk          (clk),
        .rst          (rst),
        .stall        (stall),
        .branch_valid (branch_valid),
        .peer_issue   (peer_issue),
        .peer_hole    (peer_hole),
        .idle         (idle)
    );

    assign issue = !stall && !idle;

    dsps_addr_reg #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .DIR        (DIR),
        .RESET_ADDR (RESET_ADDR)
    ) addr_i (
        .clk           (clk),
        .rst           (rst),
        .advance       (issue),
        .branch_valid  (branch_valid),
        .branch_target (branch_target),
        .step_len      (step_len),
        .addr          (addr)
    );

    assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        stall |-> !issue);

endmodule

// File: rtl/dsps_seq_top.sv
module dsps_seq_top
    import dsps_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned SKIP_W     = DEF_SKIP_W,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              branch_valid,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic [LEN_W-1:0]  fwd_len,
    input  logic [LEN_W-1:0]  bwd_len,
    input  logic [SKIP_W-1:0] fwd_hole_skip,
    input  logic [SKIP_W-1:0] bwd_hole_skip,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [ADDR_W-1:0] bwd_addr,
    output logic              fwd_issue,
    output logic              bwd_issue
);
    logic [LEN_W-1:0]  len_a   [NUM_SIDES];
    logic [SKIP_W-1:0] hole_a  [NUM_SIDES];
    logic [ADDR_W-1:0] addr_a  [NUM_SIDES];
    logic              issue_a [NUM_SIDES];

    assign len_a[0]  = fwd_len;
    assign len_a[1]  = bwd_len;
    assign hole_a[0] = fwd_hole_skip;
    assign hole_a[1] = bwd_hole_skip;

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            localparam int unsigned PEER = NUM_SIDES - 1 - s;
            dsps_side #(
                .ADDR_W     (ADDR_W),
                .LEN_W      (LEN_W),
                .SKIP_W     (SKIP_W),
                .DIR        (s == 0 ? SIDE_UP : SIDE_DOWN),
                .RESET_ADDR (RESET_ADDR)
            ) side_i (
                .clk           (clk),
                .rst           (rst),
                .stall         (stall),
                .branch_valid  (branch_valid),
                .branch_target (branch_target),
                .step_len      (len_a[s]),
                .peer_issue    (issue_a[PEER]),
                .peer_hole     (hole_a[PEER]),
                .addr          (addr_a[s]),
                .issue         (issue_a[s])
            );
        end
    endgenerate

    assign fwd_addr  = addr_a[0];
    assign bwd_addr  = addr_a[1];
    assign fwd_issue = issue_a[0];
    assign bwd_issue = issue_a[1];

    assert_shared_entry_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(branch_valid)) |-> (fwd_addr == bwd_addr));

endmodule

// File: tb/dsps_seq_top_tb_top.sv
module dsps_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic        branch_valid;
    logic [31:0] branch_target;
    logic [5:0]  fwd_len, bwd_len;
    logic [2:0]  fwd_hole_skip, bwd_hole_skip;
    logic [31:0] fwd_addr, bwd_addr;
    logic        fwd_issue, bwd_issue;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dsps_seq_top dut_i (
        .clk(clk), .rst(rst), .stall(stall),
        .branch_valid(branch_valid), .branch_target(branch_target),
        .fwd_len(fwd_len), .bwd_len(bwd_len),
        .fwd_hole_skip(fwd_hole_skip), .bwd_hole_skip(bwd_hole_skip),
        .fwd_addr(fwd_addr), .bwd_addr(bwd_addr),
        .fwd_issue(fwd_issue), .bwd_issue(bwd_issue)
    );

    typedef struct packed {
        logic        br;
        logic [31:0] tgt;
        logic        st;
        logic [5:0]  fl;
        logic [5:0]  bl;
        logic [2:0]  fh;
        logic [2:0]  bh;
        logic [31:0] ef;
        logic [31:0] eb;
        logic        efi;
        logic        ebi;
    } vec_t;

    localparam int NV = 15;
    // Expected columns are the outputs seen in that row's cycle, before its edge.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h1000, 1'b0, 6'd8,  6'd12, 3'd0, 3'd0, 32'h0000, 32'h0000, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd8,  6'd12, 3'd0, 3'd0, 32'h1000, 32'h1000, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd16, 6'd4,  3'd2, 3'd0, 32'h1008, 32'h0FF4, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd4,  6'd20, 3'd5, 3'd0, 32'h1018, 32'h0FF0, 1'b1, 1'b0},
        '{1'b0, 32'h0,    1'b0, 6'd4,  6'd20, 3'd0, 3'd0, 32'h101C, 32'h0FF0, 1'b1, 1'b0},
        '{1'b0, 32'h0,    1'b1, 6'd4,  6'd8,  3'd3, 3'd3, 32'h1020, 32'h0FF0, 1'b0, 1'b0},
        '{1'b0, 32'h0,    1'b0, 6'd4,  6'd8,  3'd0, 3'd1, 32'h1020, 32'h0FF0, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd4,  6'd8,  3'd0, 3'd0, 32'h1024, 32'h0FE8, 1'b0, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd2,  6'd2,  3'd1, 3'd1, 32'h1024, 32'h0FE0, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd2,  6'd2,  3'd0, 3'd0, 32'h1026, 32'h0FDE, 1'b0, 1'b0},
        '{1'b1, 32'h2000, 1'b1, 6'd2,  6'd2,  3'd0, 3'd0, 32'h1026, 32'h0FDE, 1'b0, 1'b0},
        '{1'b0, 32'h0,    1'b0, 6'd6,  6'd6,  3'd4, 3'd0, 32'h2000, 32'h2000, 1'b1, 1'b1},
        '{1'b1, 32'h3000, 1'b0, 6'd6,  6'd6,  3'd0, 3'd0, 32'h2006, 32'h1FFA, 1'b1, 1'b0},
        '{1'b0, 32'h0,    1'b0, 6'd1,  6'd1,  3'd0, 3'd0, 32'h3000, 32'h3000, 1'b1, 1'b1},
        '{1'b0, 32'h0,    1'b0, 6'd0,  6'd0,  3'd0, 3'd0, 32'h3001, 32'h2FFF, 1'b1, 1'b1}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R1 reset state / R2 branch";
            1:       return "R2 entry load";
            2:       return "R3 R4 step, R9 zero hole";
            3:       return "R6 backward idle, R8 hole ignored";
            4:       return "R6 backward idle second cycle";
            5:       return "R5 stall";
            6:       return "R6 resume, R7 hole";
            7:       return "R7 forward idle";
            8:       return "R8 counts resolved, R9 both holes";
            9:       return "R9 both idle";
            10:      return "R10 branch under stall";
            11:      return "R10 target loaded";
            12:      return "R2 branch during idle";
            13:      return "R2 counters cleared";
            default: return "R3 R4 final step";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [31:0] ef, input logic [31:0] eb,
                           input logic efi, input logic ebi);
        chk(tag, "fwd_addr", fwd_addr, ef);
        chk(tag, "bwd_addr", bwd_addr, eb);
        chk(tag, "fwd_issue", {31'b0, fwd_issue}, {31'b0, efi});
        chk(tag, "bwd_issue", {31'b0, bwd_issue}, {31'b0, ebi});
    endtask

    task automatic drive(input logic br, input logic [31:0] tgt, input logic st,
                         input logic [5:0] fl, input logic [5:0] bl,
                         input logic [2:0] fh, input logic [2:0] bh);
        branch_valid  = br;
        branch_target = tgt;
        stall         = st;
        fwd_len       = fl;
        bwd_len       = bl;
        fwd_hole_skip = fh;
        bwd_hole_skip = bh;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 6'd0, 6'd0, 3'd0, 3'd0);
        repeat (2) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].br, VECS[i].tgt, VECS[i].st, VECS[i].fl, VECS[i].bl,
                  VECS[i].fh, VECS[i].bh);
            #1;
            chk_all(row_tag(i), VECS[i].ef, VECS[i].eb, VECS[i].efi, VECS[i].ebi);
            @(negedge clk);
        end

        // R1: mid-run reset returns both addresses to zero with both sides issuing
        rst = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 6'd0, 6'd0, 3'd0, 3'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_all("R1 reset mid-run", 32'h0, 32'h0, 1'b1, 1'b1);

        // R6 with R5: backward idle of 2 pending across a 3-cycle stall
        drive(1'b0, 32'h0, 1'b0, 6'd4, 6'd4, 3'd2, 3'd0);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, 32'h0, 1'b1, 6'd4, 6'd4, 3'd0, 3'd0);
            #1;
            chk_all("R5 stall freezes pending idle", 32'h4, 32'hFFFF_FFFC, 1'b0, 1'b0);
            @(negedge clk);
        end
        drive(1'b0, 32'h0, 1'b0, 6'd4, 6'd4, 3'd0, 3'd0);
        #1;
        chk_all("R5 idle count kept after stall", 32'h4, 32'hFFFF_FFFC, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        chk_all("R6 second idle cycle", 32'h8, 32'hFFFF_FFFC, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        chk_all("R6 backward resumes", 32'hC, 32'hFFFF_FFFC, 1'b1, 1'b1);
        @(negedge clk);
        #1;
        chk_all("R4 wrap below zero", 32'h10, 32'hFFFF_FFF8, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule